// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block is one 9-bit slice of a transceiver that sits between two buses, called A and B. Each bus is modelled as three signals: an input from the bus, a value to drive onto it, and a drive enable. Each direction has its own storage register with its own clock. Each direction also has a select that forwards either the live data from the far bus or the value held in that direction's register. The B side is driven while an active-high enable is asserted. The A side is driven while an active-low enable is asserted.

A register captures the resolved value of its source bus on every rising edge of its clock, whatever the state of the enables. The resolved value is the driven value when that bus is driven by this block, and the bus input otherwise. As a result, with live A data forwarded onto B, one clock on each side loads the A value into both registers. A low-active asynchronous reset clears both registers. The `*_out` values are produced whatever the state of the enables. A higher level turns them into drivers using the `*_oe` flags.

Top module: `reg_bus_xcvr`

## Requirements
- R1: `b_oe` is 1 exactly when `oe_ab` is 1 (active-high B drive enable).
- R2: `a_oe` is 1 exactly when `oe_ba_n` is 0 (active-low A drive enable).
- R3: On each rising edge of `clk_ab`, the A register loads the resolved A value: `a_out` if `a_oe` is 1, else `a_in`. This happens for every enable setting.
- R4: On each rising edge of `clk_ba`, the B register loads the resolved B value: `b_out` if `b_oe` is 1, else `b_in`. This happens for every enable setting.
- R5: With `sel_ab` = 0, `b_out` equals the live `a_in`.
- R6: With `sel_ab` = 1, `b_out` equals the A register.
- R7: With `sel_ba` = 0, `a_out` equals the live `b_in`. With `sel_ba` = 1, `a_out` equals the B register.
- R8: With `oe_ab` = 0 and `oe_ba_n` = 1, both drive enables are 0, and both registers still load on their clocks.
- R9: With both sides driven and both selects at 1, each bus carries the other side's stored value. If both clocks then rise together, the two registers exchange contents.
- R10: With B driven from live A and A not driven, a rising edge on both clocks loads `a_in` into both registers. The mirror case (A driven from live B, B not driven) loads `b_in` into both registers.
- R11: While `rst_n` is 0, both registers are 0.
- R12: A register keeps its value between rising edges of its own clock, even when the bus inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low; clears both registers |
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| oe_ab | input | 1 | B side drive enable, active high |
| oe_ba_n | input | 1 | A side drive enable, active low |
| sel_ab | input | 1 | 0: live A onto B, 1: stored A onto B |
| sel_ba | input | 1 | 0: live B onto A, 1: stored B onto A |
| a_in | input | WIDTH | Value present on the A bus |
| a_out | output | WIDTH | Value to drive onto the A bus |
| a_oe | output | 1 | A side drive enable |
| b_in | input | WIDTH | Value present on the B bus |
| b_out | output | WIDTH | Value to drive onto the B bus |
| b_oe | output | 1 | B side drive enable |

## Verification
The bench loads the registers while both sides are isolated. A design that gated capture with the enables would then show stale stored data. It clocks both registers together while each side drives the other's stored value. A design that captured the raw bus inputs instead of the resolved values would fail to exchange the contents, and one with a combinational loop would settle to garbage. The load-both case is run in both directions to catch a resolution applied on one side only. Changing inputs with no clock, and resetting in the middle of the run, expose registers that follow the bus or that survive reset.

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
  parameter int WIDTH = 9
) (
  input  logic             rst_n,
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             oe_ab,
  input  logic             oe_ba_n,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  logic [WIDTH-1:0] store_a, store_b;
  logic [WIDTH-1:0] a_bus, b_bus;

  assign b_oe  = oe_ab;
  assign a_oe  = ~oe_ba_n;

  // live paths take the far bus input, so no loop forms when both sides drive
  assign b_out = sel_ab ? store_a : a_in;
  assign a_out = sel_ba ? store_b : b_in;

  assign a_bus = a_oe ? a_out : a_in;
  assign b_bus = b_oe ? b_out : b_in;

  always_ff @(posedge clk_ab or negedge rst_n)
    if (!rst_n) store_a <= '0;
    else        store_a <= a_bus;

  always_ff @(posedge clk_ba or negedge rst_n)
    if (!rst_n) store_b <= '0;
    else        store_b <= b_bus;

endmodule

// File: rtl/reg_bus_xcvr_chk.sv
module reg_bus_xcvr_chk #(
  parameter int WIDTH = 9
) (
  input logic             rst_n,
  input logic             clk_ab,
  input logic             clk_ba,
  input logic             oe_ab,
  input logic             oe_ba_n,
  input logic             sel_ab,
  input logic             sel_ba,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe
);

  logic [WIDTH-1:0] a_res, b_res;
  logic seen_ab, seen_ba;

  assign a_res = a_oe ? a_out : a_in;
  assign b_res = b_oe ? b_out : b_in;

  always_ff @(posedge clk_ab or negedge rst_n)
    if (!rst_n) seen_ab <= 1'b0;
    else        seen_ab <= 1'b1;

  always_ff @(posedge clk_ba or negedge rst_n)
    if (!rst_n) seen_ba <= 1'b0;
    else        seen_ba <= 1'b1;

  // R3, R6
  a_r3_stored_ab: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (seen_ab && sel_ab) |-> (b_out == $past(a_res)));

  // R4, R7
  a_r4_stored_ba: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (seen_ba && sel_ba) |-> (a_out == $past(b_res)));

  a_r5_live_ab: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !sel_ab |-> (b_out == a_in));

  a_r7_live_ba: assert property (@(posedge clk_ba) disable iff (!rst_n)
    !sel_ba |-> (a_out == b_in));

  a_r8_isolate: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!oe_ab && oe_ba_n) |-> (!a_oe && !b_oe));

  a_r9_both_drive: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (oe_ab && !oe_ba_n) |-> (a_oe && b_oe));

endmodule

bind reg_bus_xcvr reg_bus_xcvr_chk #(.WIDTH(WIDTH)) chk (.*);

// File: tb/reg_bus_xcvr_test.sv
module reg_bus_xcvr_test;
  localparam int W = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic clk_ab = 1'b0, clk_ba = 1'b0;
  logic oe_ab = 1'b0, oe_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  reg_bus_xcvr #(.WIDTH(W)) uut (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [W-1:0] a_out;
    logic         a_oe;
    logic [W-1:0] b_out;
    logic         b_oe;
    string        req;
  } exp_t;

  exp_t q[$];
  int n_vec = 0, n_bad = 0;
  logic [W-1:0] ma = '0, mb = '0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (a_out !== e.a_out || a_oe !== e.a_oe || b_out !== e.b_out || b_oe !== e.b_oe) begin
        n_bad++;
        $display("FAIL %s: got a_out=%h a_oe=%b b_out=%h b_oe=%b, want a_out=%h a_oe=%b b_out=%h b_oe=%b",
                 e.req, a_out, a_oe, b_out, b_oe, e.a_out, e.a_oe, e.b_out, e.b_oe);
      end
    end
  end

  task automatic push(input string req);
    exp_t e;
    e.a_out = sel_ba ? mb : b_in;
    e.a_oe  = ~oe_ba_n;
    e.b_out = sel_ab ? ma : a_in;
    e.b_oe  = oe_ab;
    e.req   = req;
    q.push_back(e);
  endtask

  task automatic step(input logic oeab, input logic oebn, input logic sab, input logic sba,
                      input logic [W-1:0] ain, input logic [W-1:0] bin,
                      input bit pab, input bit pba, input string req);
    logic [W-1:0] na, nb;
    @(posedge clk); #1;
    oe_ab = oeab; oe_ba_n = oebn; sel_ab = sab; sel_ba = sba; a_in = ain; b_in = bin;
    #2;
    na = !oebn ? (sba ? mb : bin) : ain;
    nb = oeab  ? (sab ? ma : ain) : bin;
    clk_ab = pab; clk_ba = pba;
    if (pab) ma = na;
    if (pba) mb = nb;
    #1; clk_ab = 1'b0; clk_ba = 1'b0;
    push(req);
  endtask

  task automatic do_reset(input string req);
    @(posedge clk); #1;
    rst_n = 1'b0; ma = '0; mb = '0;
    sel_ab = 1'b1; sel_ba = 1'b1;
    #3; push(req);
    @(posedge clk); #1; rst_n = 1'b1;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset("R11 initial reset");
    // enables, all four combinations
    step(0, 1, 0, 0, 9'h011, 9'h022, 0, 0, "R1 R2 R8 isolation");
    step(1, 1, 0, 0, 9'h011, 9'h022, 0, 0, "R1 B enabled");
    step(0, 0, 0, 0, 9'h011, 9'h022, 0, 0, "R2 A enabled");
    step(1, 0, 0, 0, 9'h011, 9'h022, 0, 0, "R1 R2 both enabled");
    // live paths
    step(1, 1, 0, 0, 9'h1A5, 9'h022, 0, 0, "R5 live A to B");
    step(0, 0, 0, 0, 9'h011, 9'h0C9, 0, 0, "R7 live B to A");
    // capture while isolated
    step(0, 1, 0, 0, 9'h0F3, 9'h15A, 1, 1, "R8 capture while isolated");
    step(1, 0, 1, 1, 9'h000, 9'h000, 0, 0, "R3 R4 R6 R7 stored values");
    // hold without clock
    step(1, 0, 1, 1, 9'h1FF, 9'h1FF, 0, 0, "R12 hold on input change");
    step(1, 0, 1, 1, 9'h055, 9'h0AA, 0, 0, "R12 hold second pattern");
    // swap through stored paths
    step(1, 0, 1, 1, 9'h000, 9'h000, 1, 1, "R9 simultaneous exchange");
    step(1, 0, 1, 1, 9'h123, 9'h0BE, 0, 0, "R9 exchanged contents");
    // one-sided captures
    step(1, 0, 1, 1, 9'h000, 9'h000, 1, 0, "R3 A captures driven A value");
    step(0, 1, 1, 1, 9'h0D4, 9'h000, 1, 0, "R3 A captures a_in when undriven");
    // load both registers from A
    step(1, 1, 0, 0, 9'h1C3, 9'h02B, 1, 1, "R10 load both from A");
    step(1, 0, 1, 1, 9'h000, 9'h000, 0, 0, "R10 both hold A value");
    // mirror: load both from B
    step(0, 0, 0, 0, 9'h017, 9'h0A6, 1, 1, "R10 load both from B");
    step(1, 0, 1, 1, 9'h000, 9'h000, 0, 0, "R10 both hold B value");
    // B captures from live a_in while B driven
    step(1, 1, 0, 1, 9'h16E, 9'h000, 0, 1, "R4 B captures driven B value");
    step(0, 0, 1, 1, 9'h000, 9'h000, 0, 0, "R4 R6 stored check");
    do_reset("R11 reset mid-run");
    step(1, 0, 1, 1, 9'h1FF, 9'h1FF, 0, 0, "R11 registers cleared");
    @(posedge clk); @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule